// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives a three-phase inverter bridge. It has six pins: a high-side and a low-side output for each of the phases U, V and W. One up/down counter serves all three phases. It climbs from zero to a programmable period and then falls back to zero. Each phase compares the counter with its own compare value, so the high-side reference is asserted while the counter is below that value.

A small state machine turns each reference into a complementary pair. It holds both switches of the pair off for a programmable number of clocks every time the pair changes over. Any output can be pinned to a fixed level at any time. Software can set these fixed levels directly. A staged pattern can also be armed so that it takes effect on the exact clock where a chosen phase's counter matches its compare value while counting up, which is how 60-degree block commutation is stepped for brushless DC drive. An abnormality input forces every pin to its idle level at once and holds it there. Only a software clear issued while the input is low releases it.

The timebase has three states:
- `TB_IDLE`: stopped, counter at zero.
- `TB_UP`: counting up.
- `TB_DOWN`: counting down.

Its transitions are:
- start: `TB_IDLE` to `TB_UP` when run is set.
- peak: `TB_UP` to `TB_DOWN` at the period value.
- valley: `TB_DOWN` to `TB_UP` at zero.
- stop: any state to `TB_IDLE` when run is cleared.

Each phase's pair machine has four states:
- `DB_LOW`: low side on.
- `DB_GAP_RISE`: both off, heading high.
- `DB_HIGH`: high side on.
- `DB_GAP_FALL`: both off, heading low.

Its transitions are:
- rise: `DB_LOW` to `DB_GAP_RISE` when the reference asserts, or directly to `DB_HIGH` when the dead time is 0.
- gap done: `DB_GAP_RISE` to `DB_HIGH`, and `DB_GAP_FALL` to `DB_LOW`, once the gap has elapsed.
- abort: a gap state returns to the side it came from if the reference reverts during the gap.
- fall: `DB_HIGH` to `DB_GAP_FALL`, or directly to `DB_LOW` when the dead time is 0.
- park: any state to `DB_LOW` while the timebase is stopped.

Top module: `tri_pwm_gen`

## Requirements
- R1: After reset every pin is at its idle level. The reset idle level of every pin is 0, and the timebase is stopped.
- R2: While running, the counter steps by one per clock. It goes 0,1,...,P on the way up, then P-1,...,0 on the way down. Zero is held for two clocks, one in `TB_DOWN` and one in `TB_UP`. A period of 0 keeps the counter at zero.
- R3: Writes to the period register (address 0) and to the compare registers (addresses 1, 2 and 3 for phases U, V and W) go to shadow copies. The working copies take the shadow value only on a clock edge where the counter is zero, or while stopped.
- R4: The high-side reference of a phase is asserted while the counter is strictly below that phase's working compare value. Pin bit 2k is the high side and bit 2k+1 is the low side of phase k, where k=0 is U, 1 is V and 2 is W. Each pair machine reacts one clock after the counter value it sees.
- R5: The dead-time register is address 4, bits [7:0], and a write takes effect at once. On every changeover the pair spends exactly that many clocks with both sides off. A value of 0 switches the pair over directly.
- R6: If the reference reverts during a gap, the pair returns at once to the side that was on before the gap, with no further gap.
- R7: The level register is address 5. Bit i of [5:0] pins output i to a fixed level, and bit 8+i gives that level (1 means active). It takes effect on the clock after the write.
- R8: The staged register is address 7. It holds a pattern in the same layout as the level register, a source phase in bits [7:6] (0 to 2, where 3 never fires) and an arm bit in bit 15. While armed, the pattern is copied into the level register on the edge where the counter equals the source phase's working compare value in `TB_UP`, and the arm bit then clears.
- R9: The idle-level register is address 6, bits [5:0]. A pin shows its idle bit when inactive and the inverse of that bit when active.
- R10: A high fault input drives all pins to their idle levels immediately, without waiting for a clock, and latches. The latch is released only by writing bit 1 of the command register (address 8) while the fault input is low. Such a write made while the input is high has no effect.
- R11: Bit 0 of the command register (address 8) is the run bit. Clearing it returns the timebase to `TB_IDLE` with the counter at zero, parks all pair machines in `DB_LOW` and drives every pin to its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW (16) | Register write data |
| fault_in | input | 1 | Abnormality input, active high |
| pwm_out | output | 6 | Bridge outputs {WB,W,VB,V,UB,U} |

## Verification
A register write lands at the clock edge that samples it. The level, idle and command registers affect the pins right after that edge. A new period or compare value waits for the next zero of the counter. A counter crossing shows on a pin one clock after the counter changes, plus the dead time, because the pair machine is registered. The fault input reaches the pins through logic only, with no register in the path. The bench steps a behavioural model at each rising edge using the values present before that edge. It compares all six pins 5 ns later, once every register and every fault path has settled, and it adds directed checks for the reset, fault-hold, commutation and stop cases.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_UP   = 2'd1,
        TB_DOWN = 2'd2
    } tb_state_e;

    typedef enum logic [1:0] {
        DB_LOW      = 2'd0,
        DB_GAP_RISE = 2'd1,
        DB_HIGH     = 2'd2,
        DB_GAP_FALL = 2'd3
    } db_state_e;

    localparam logic [3:0] A_PERIOD = 4'd0;
    localparam logic [3:0] A_CMP0   = 4'd1;
    localparam logic [3:0] A_DEAD   = 4'd4;
    localparam logic [3:0] A_LEVEL  = 4'd5;
    localparam logic [3:0] A_IDLE   = 4'd6;
    localparam logic [3:0] A_STAGE  = 4'd7;
    localparam logic [3:0] A_CMD    = 4'd8;

endpackage

// File: rtl/tpwm_timebase.sv
module tpwm_timebase
    import tpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] per_shadow,
    output logic [CW-1:0] cnt,
    output logic          counting_up,
    output logic          running,
    output logic          at_zero
);

    tb_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] per_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= TB_IDLE;
            cnt_q   <= '0;
            per_act <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (cnt_q == '0) per_act <= per_shadow;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            TB_IDLE: begin
                cnt_d = '0;
                if (run) st_d = TB_UP;
            end
            TB_UP: begin
                if (!run) begin
                    st_d  = TB_IDLE;
                    cnt_d = '0;
                end else if (cnt_q >= per_act) begin
                    st_d  = TB_DOWN;
                    cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            TB_DOWN: begin
                if (!run) begin
                    st_d  = TB_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == '0) begin
                    st_d = TB_UP;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                st_d  = TB_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    assign cnt         = cnt_q;
    assign counting_up = (st_q == TB_UP);
    assign running     = (st_q != TB_IDLE);
    assign at_zero     = (cnt_q == '0);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_act);

    // R2
    valley_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TB_DOWN && cnt_q == '0 && run) |=> (st_q == TB_UP && cnt_q == '0));

    // R3
    per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> $stable(per_act));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q == TB_IDLE && cnt_q == '0));

endmodule

// File: rtl/tpwm_deadband.sv
module tpwm_deadband
    import tpwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ref_hi,
    input  logic [DW-1:0] dead,
    output logic          hi_on,
    output logic          lo_on
);

    db_state_e     st_q, st_d;
    logic [DW-1:0] gap_q, gap_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DB_LOW;
            gap_q <= '0;
        end else begin
            st_q  <= st_d;
            gap_q <= gap_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        gap_d = gap_q;
        if (!en) begin
            st_d  = DB_LOW;
            gap_d = '0;
        end else begin
            unique case (st_q)
                DB_LOW: begin
                    if (ref_hi) begin
                        st_d  = (dead == '0) ? DB_HIGH : DB_GAP_RISE;
                        gap_d = dead;
                    end
                end
                DB_GAP_RISE: begin
                    if (!ref_hi)                  st_d = DB_LOW;
                    else if (gap_q <= DW'(1))     st_d = DB_HIGH;
                    else                          gap_d = gap_q - 1'b1;
                end
                DB_HIGH: begin
                    if (!ref_hi) begin
                        st_d  = (dead == '0) ? DB_LOW : DB_GAP_FALL;
                        gap_d = dead;
                    end
                end
                DB_GAP_FALL: begin
                    if (ref_hi)                   st_d = DB_HIGH;
                    else if (gap_q <= DW'(1))     st_d = DB_LOW;
                    else                          gap_d = gap_q - 1'b1;
                end
                default: st_d = DB_LOW;
            endcase
        end
    end

    assign hi_on = (st_q == DB_HIGH);
    assign lo_on = (st_q == DB_LOW);

    // R5
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == DB_LOW && ref_hi && dead != '0) |=> (st_q == DB_GAP_RISE));

    // R5
    gap_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == DB_GAP_RISE && ref_hi && gap_q > DW'(1))
            |=> (st_q == DB_GAP_RISE && gap_q == $past(gap_q) - 1'b1));

    // R6
    gap_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q == DB_GAP_FALL && ref_hi) |=> (st_q == DB_HIGH));

endmodule

// File: rtl/tpwm_fault_latch.sv
module tpwm_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic clr_req,
    output logic fault_hold
);

    logic hold_q;

    always_ff @(posedge clk or negedge rst_n or posedge fault_in) begin
        if (!rst_n)        hold_q <= 1'b0;
        else if (fault_in) hold_q <= 1'b1;
        else if (clr_req)  hold_q <= 1'b0;
    end

    assign fault_hold = hold_q;

    // R10
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> hold_q);

    // R10
    fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !clr_req) |=> hold_q);

endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
    import tpwm_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          fault_in,
    output logic [5:0]    pwm_out
);

    localparam int NPH  = 3;
    localparam int NOUT = 2 * NPH;
    localparam int VOFS = 8;
    localparam int ARMB = 15;

    logic [CW-1:0]          per_sh;
    logic [NPH-1:0][CW-1:0] cmp_sh;
    logic [NPH-1:0][CW-1:0] cmp_act;
    logic [DW-1:0]          dead_q;
    logic [NOUT-1:0]        lvl_en_q, lvl_val_q, idle_q;
    logic [NOUT-1:0]        stg_en_q, stg_val_q;
    logic [1:0]             stg_src_q;
    logic                   stg_arm_q;
    logic                   run_q;

    logic [CW-1:0]          cnt;
    logic                   up, running, at_zero;
    logic                   fault_hold, clr_req;
    logic [CW-1:0]          src_cmp;
    logic                   src_ok, match_hit;
    logic [NOUT-1:0]        fsm_on;

    tpwm_timebase #(.CW(CW)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .per_shadow  (per_sh),
        .cnt         (cnt),
        .counting_up (up),
        .running     (running),
        .at_zero     (at_zero)
    );

    always_comb begin
        src_ok  = 1'b1;
        src_cmp = '0;
        unique case (stg_src_q)
            2'd0:    src_cmp = cmp_act[0];
            2'd1:    src_cmp = cmp_act[1];
            2'd2:    src_cmp = cmp_act[2];
            default: src_ok  = 1'b0;
        endcase
    end

    assign match_hit = stg_arm_q && src_ok && up && (cnt == src_cmp);
    assign clr_req   = wr_en && (wr_addr == A_CMD) && wr_data[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh    <= '0;
            cmp_sh    <= '0;
            cmp_act   <= '0;
            dead_q    <= '0;
            lvl_en_q  <= '0;
            lvl_val_q <= '0;
            idle_q    <= '0;
            stg_en_q  <= '0;
            stg_val_q <= '0;
            stg_src_q <= '0;
            stg_arm_q <= 1'b0;
            run_q     <= 1'b0;
        end else begin
            if (at_zero) cmp_act <= cmp_sh;
            if (match_hit) begin
                lvl_en_q  <= stg_en_q;
                lvl_val_q <= stg_val_q;
                stg_arm_q <= 1'b0;
            end
            if (wr_en) begin
                for (int k = 0; k < NPH; k++) begin
                    if (wr_addr == A_CMP0 + 4'(k)) cmp_sh[k] <= wr_data;
                end
                case (wr_addr)
                    A_PERIOD: per_sh <= wr_data;
                    A_DEAD:   dead_q <= wr_data[DW-1:0];
                    A_LEVEL: begin
                        lvl_en_q  <= wr_data[NOUT-1:0];
                        lvl_val_q <= wr_data[VOFS +: NOUT];
                    end
                    A_IDLE:   idle_q <= wr_data[NOUT-1:0];
                    A_STAGE: begin
                        stg_en_q  <= wr_data[NOUT-1:0];
                        stg_src_q <= wr_data[7:6];
                        stg_val_q <= wr_data[VOFS +: NOUT];
                        stg_arm_q <= wr_data[ARMB];
                    end
                    A_CMD:    run_q <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic ref_hi;
        assign ref_hi = (cnt < cmp_act[p]);
        tpwm_deadband #(.DW(DW)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (running),
            .ref_hi (ref_hi),
            .dead   (dead_q),
            .hi_on  (fsm_on[2*p]),
            .lo_on  (fsm_on[2*p+1])
        );
    end

    tpwm_fault_latch u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_in   (fault_in),
        .clr_req    (clr_req),
        .fault_hold (fault_hold)
    );

    always_comb begin
        for (int i = 0; i < NOUT; i++) begin
            if (!running || fault_hold || fault_in)
                pwm_out[i] = idle_q[i];
            else
                pwm_out[i] = idle_q[i] ^ (lvl_en_q[i] ? lvl_val_q[i] : fsm_on[i]);
        end
    end

    // R3
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !at_zero |=> $stable(cmp_act));

    // R8
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_hit && !(wr_en && wr_addr == A_STAGE)) |=> !stg_arm_q);

    // R10
    fault_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hold |-> (pwm_out == idle_q));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pwm_out == idle_q));

endmodule

// File: tb/sim_tri_pwm_gen.sv
`timescale 1ns/1ps
module sim_tri_pwm_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_in = 1'b0;
    logic [5:0]  pwm_out;

    always #10 clk = ~clk;

    tri_pwm_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fault_in (fault_in),
        .pwm_out  (pwm_out)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    chk_en   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // behavioural reference model state
    int m_st, m_cnt, m_per, m_per_sh, m_dead, m_run;
    int m_cmp[3], m_cmp_sh[3], m_db[3], m_gap[3];
    int m_lvl_en, m_lvl_val, m_idle, m_stg_en, m_stg_val, m_stg_src, m_arm;
    bit m_flt;

    always @(posedge fault_in) m_flt = 1;

    function automatic logic [5:0] expect_pins();
        logic [5:0] e;
        for (int i = 0; i < 6; i++) begin
            bit act;
            if (m_lvl_en[i]) act = m_lvl_val[i];
            else if (i % 2 == 0) act = (m_db[i/2] == 2);
            else act = (m_db[i/2] == 0);
            if (m_st == 0 || m_flt || fault_in) e[i] = m_idle[i];
            else e[i] = m_idle[i] ^ act;
        end
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_per = 0; m_per_sh = 0; m_dead = 0; m_run = 0;
            m_lvl_en = 0; m_lvl_val = 0; m_idle = 0; m_stg_en = 0; m_stg_val = 0;
            m_stg_src = 0; m_arm = 0; m_flt = 0;
            for (int p = 0; p < 3; p++) begin
                m_cmp[p] = 0; m_cmp_sh[p] = 0; m_db[p] = 0; m_gap[p] = 0;
            end
        end else begin
            int nd[3], ng[3], nst, ncnt;
            // pair machines
            for (int p = 0; p < 3; p++) begin
                bit r;
                r = (m_cnt < m_cmp[p]);
                nd[p] = m_db[p]; ng[p] = m_gap[p];
                if (m_st == 0) begin nd[p] = 0; ng[p] = 0; end
                else case (m_db[p])
                    0: if (r) begin nd[p] = (m_dead == 0) ? 2 : 1; ng[p] = m_dead; end
                    1: if (!r) nd[p] = 0; else if (m_gap[p] <= 1) nd[p] = 2; else ng[p] = m_gap[p] - 1;
                    2: if (!r) begin nd[p] = (m_dead == 0) ? 0 : 3; ng[p] = m_dead; end
                    default: if (r) nd[p] = 2; else if (m_gap[p] <= 1) nd[p] = 0; else ng[p] = m_gap[p] - 1;
                endcase
            end
            // staged commutation
            if (m_arm != 0 && m_stg_src < 3 && m_st == 1 && m_cnt == m_cmp[m_stg_src]) begin
                m_lvl_en = m_stg_en; m_lvl_val = m_stg_val; m_arm = 0;
            end
            // timebase
            nst = m_st; ncnt = m_cnt;
            if (m_st == 0) begin ncnt = 0; if (m_run != 0) nst = 1; end
            else if (m_run == 0) begin nst = 0; ncnt = 0; end
            else if (m_st == 1) begin
                if (m_cnt >= m_per) begin nst = 2; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else ncnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) nst = 1; else ncnt = m_cnt - 1;
            end
            if (m_cnt == 0) begin
                m_per = m_per_sh;
                for (int p = 0; p < 3; p++) m_cmp[p] = m_cmp_sh[p];
            end
            m_st = nst; m_cnt = ncnt;
            for (int p = 0; p < 3; p++) begin m_db[p] = nd[p]; m_gap[p] = ng[p]; end
            // fault latch
            if (fault_in) m_flt = 1;
            else if (wr_en && wr_addr == 4'd8 && wr_data[1]) m_flt = 0;
            // register writes
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_per_sh = wr_data;
                    4'd1: m_cmp_sh[0] = wr_data;
                    4'd2: m_cmp_sh[1] = wr_data;
                    4'd3: m_cmp_sh[2] = wr_data;
                    4'd4: m_dead = wr_data[7:0];
                    4'd5: begin m_lvl_en = wr_data[5:0]; m_lvl_val = wr_data[13:8]; end
                    4'd6: m_idle = wr_data[5:0];
                    4'd7: begin
                        m_stg_en = wr_data[5:0]; m_stg_val = wr_data[13:8];
                        m_stg_src = wr_data[7:6]; m_arm = wr_data[15];
                    end
                    4'd8: m_run = wr_data[0];
                    default: ;
                endcase
            end
        end
        #5;
        if (chk_en) begin
            logic [5:0] e;
            e = expect_pins();
            n_checks++;
            if (pwm_out !== e) begin
                n_fail++;
                $display("FAIL %s cycle compare: pwm_out=%b expected=%b", cur_req, pwm_out, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pins(input string req, input logic [5:0] exp_v);
        n_checks++;
        if (pwm_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s directed: pwm_out=%b expected=%b", req, pwm_out, exp_v);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, idle level 0 on every pin
        check_pins("R1", 6'b000000);
        chk_en = 1;

        // R2 and R4: triangle counter, compare against three phases, no dead time
        cur_req = "R2_R4";
        wr(4'd0, 16'd20);
        wr(4'd1, 16'd5);
        wr(4'd2, 16'd10);
        wr(4'd3, 16'd15);
        wr(4'd4, 16'd0);
        wr(4'd8, 16'h0001);
        idle_cycles(90);

        // R5: dead time of three clocks
        cur_req = "R5";
        wr(4'd4, 16'd3);
        idle_cycles(90);

        // R3: mid-cycle shadow writes wait for the zero point
        cur_req = "R3";
        idle_cycles(7);
        wr(4'd0, 16'd12);
        wr(4'd1, 16'd18);
        idle_cycles(100);

        // R6: references shorter than the dead time abort the gap
        cur_req = "R6";
        wr(4'd0, 16'd20);
        wr(4'd1, 16'd1);
        wr(4'd2, 16'd20);
        wr(4'd4, 16'd5);
        idle_cycles(120);

        // R9: per-pin idle level flips polarity
        cur_req = "R9";
        wr(4'd6, 16'h002A);
        idle_cycles(80);
        wr(4'd6, 16'h0000);

        // R7: U high side forced on, U low side forced off
        cur_req = "R7";
        wr(4'd5, 16'h0103);
        idle_cycles(60);
        wr(4'd5, 16'h0000);

        // R8: staged pattern on phase V match, all outputs fixed, U and VB on
        cur_req = "R8";
        wr(4'd2, 16'd10);
        wr(4'd7, 16'h8000 | 16'h0900 | 16'h0040 | 16'h003F);
        idle_cycles(100);
        check_pins("R8", 6'b001001);
        wr(4'd5, 16'h0000);
        idle_cycles(20);

        // R10: fault forcing, latch, ignored clear, real clear
        cur_req = "R10";
        wr(4'd6, 16'h0015);
        idle_cycles(5);
        fault_in = 1'b1;
        idle_cycles(3);
        fault_in = 1'b0;
        idle_cycles(10);
        check_pins("R10", 6'b010101);
        fault_in = 1'b1;
        wr(4'd8, 16'h0003);
        fault_in = 1'b0;
        idle_cycles(5);
        check_pins("R10", 6'b010101);
        wr(4'd8, 16'h0003);
        idle_cycles(40);

        // R11: stop returns every pin to idle
        cur_req = "R11";
        wr(4'd8, 16'h0000);
        idle_cycles(4);
        check_pins("R11", 6'b010101);
        idle_cycles(5);

        done = 1;
        chk_en = 0;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule